// File: doc/BRIEF.md
# Interrupt Sequencer with Global Enable

This block sits between peripheral interrupt sources and a small 8-bit processor core. Each source raises a one-cycle set pulse that latches a pending flag. Software can clear any flag by writing a 1 to its bit position. A flag becomes a candidate for service only when its per-source enable and the global enable are both on. Among the candidates the lowest source index wins.

The core reports every retired instruction. When a candidate exists at an instruction boundary, the sequencer accepts it and runs a four-cycle entry:
- the entry clears the global enable;
- it acknowledges the chosen source and clears that source's flag;
- it pushes the return program counter through the stack port.

A two-cycle jump then loads the vector address, which is the source index plus one; address 0 stays reserved for reset. A retiring return-from-interrupt runs a four-cycle return sequence instead. That sequence pops the saved program counter, loads it into the core and sets the global enable again. After a return, exactly one main-program instruction must retire before another source can be accepted. Saving the status register is left to software.

The state machine has five states:
- `ST_RUN`: normal execution.
- `ST_ENTRY`: four cycles of acknowledge and push.
- `ST_JUMP`: two cycles that end with the vector load.
- `ST_RETURN`: four cycles of pop and load.
- `ST_ONE_INSN`: waits for the single instruction that must follow a return.

The transitions are:
- RUN→RETURN on a retiring return instruction.
- RUN→ENTRY on a retire with a candidate and the global enable on.
- ENTRY→JUMP after its fourth cycle.
- JUMP→RUN after its second cycle.
- RETURN→ONE_INSN after its fourth cycle.
- ONE_INSN→RUN on the next plain retire.
- ONE_INSN→RETURN on a retiring return instruction.

Top module: `isq_top`

## Requirements
- R1: While reset is held, all flags, the global enable, `hold_o` and every strobe (`ack_o`, `push_o`, `pop_o`, `pc_load_o`) are 0.
- R2: A set pulse on bit i makes flag i read 1 on `flags_o` from the next cycle on. The flag stays set while its source enable or the global enable is off.
- R3: A flag-clear write clears every flag whose data bit is 1 and leaves the others unchanged; a write of all zeros has no effect. A set pulse in the same cycle as a clear of the same bit wins, so the flag stays 1.
- R4: Acceptance happens only on a cycle with `instr_retire_i`=1, the global enable on, and at least one flag whose source enable is on. The source with the lowest index is chosen.
- R5: In the first cycle after acceptance, `ack_o` is 1 for exactly one cycle, `ack_id_o` carries the source index, and `gie_o` is 0. The flag of that source is cleared at the end of that cycle unless a set pulse for it arrives in the same cycle.
- R6: In the second cycle after acceptance, `push_o` is 1 for one cycle, and `push_data_o` equals the `pc_i` sampled at acceptance.
- R7: In the sixth cycle after acceptance, `pc_load_o` is 1 and `pc_load_addr_o` equals the source index plus 1. `hold_o` is 1 for exactly those six cycles.
- R8: A retire with `reti_i`=1 starts the return sequence:
  - `pop_o` is 1 in the first cycle, and `pop_data_i` is sampled in the second.
  - In the fourth cycle `pc_load_o` loads the popped value.
  - `gie_o` reads 1 from the fifth cycle.
- R9: After a return, the first retire never causes acceptance, even when a candidate is pending; the retire after it can.
- R10: A write on `gie_wr_i` outside the sequences sets `gie_o` to `gie_wdata_i` from the next cycle.
- R11: When a retire carries `reti_i`=1 while a candidate is pending and the global enable is on, the return sequence runs and no acknowledge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_set_i | input | NUM_SRC | One-cycle set pulses, one per source |
| src_en_i | input | NUM_SRC | Per-source enable mask |
| flag_clr_we_i | input | 1 | Flag-clear write strobe |
| flag_clr_data_i | input | NUM_SRC | Ones mark the flags to clear |
| gie_wr_i | input | 1 | Software write strobe for the global enable |
| gie_wdata_i | input | 1 | Value written to the global enable |
| instr_retire_i | input | 1 | Core retired an instruction this cycle |
| reti_i | input | 1 | The retiring instruction is a return-from-interrupt |
| pc_i | input | PC_W | Return address offered by the core at retire |
| pop_data_i | input | PC_W | Stack read data, valid the cycle after `pop_o` |
| flags_o | output | NUM_SRC | Pending flags |
| gie_o | output | 1 | Global enable |
| hold_o | output | 1 | Core is stalled during entry, jump and return |
| ack_o | output | 1 | One-cycle acknowledge |
| ack_id_o | output | IDW | Acknowledged source index |
| push_o | output | 1 | Stack push strobe |
| push_data_o | output | PC_W | Program counter to push |
| pop_o | output | 1 | Stack pop strobe |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_load_addr_o | output | PC_W | Address to load |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the hardware clear of the acknowledged flag and a fresh set pulse for that same source. The bench drives the set pulse in the acknowledge cycle. It then judges the outcome by the flag still reading 1 after the entry, and by that source being accepted again later.

The second pair is a retiring return-from-interrupt and a pending, enabled candidate with the global enable on. Software turns the enable back on inside the handler to provoke this case. The scoreboard then expects only a pop and a load, with no acknowledge, followed by one plain retire before the next acceptance.

// File: rtl/isq_pkg.sv
package isq_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_ENTRY    = 3'd1,
        ST_JUMP     = 3'd2,
        ST_RETURN   = 3'd3,
        ST_ONE_INSN = 3'd4
    } isq_state_e;

    localparam int ENTRY_CYCLES  = 4;
    localparam int JUMP_CYCLES   = 2;
    localparam int RETURN_CYCLES = 4;
    localparam int SEQ_MAX       = 4;
    localparam int SEQ_CNT_W     = $clog2(SEQ_MAX);

endpackage

// File: rtl/isq_flag_bank.sv
module isq_flag_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               clr_we_i,
    input  logic [NUM_SRC-1:0] clr_data_i,
    input  logic [NUM_SRC-1:0] hw_clr_i,
    output logic [NUM_SRC-1:0] flags_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        logic pend_q;
        logic sw_clr;

        assign sw_clr = clr_we_i && clr_data_i[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
            end else if (set_i[g]) begin
                pend_q <= 1'b1;
            end else if (sw_clr || hw_clr_i[g]) begin
                pend_q <= 1'b0;
            end
        end

        assign flags_o[g] = pend_q;
    end

endmodule

// File: rtl/isq_prio_enc.sv
module isq_prio_enc #(
    parameter int NUM_SRC = 8,
    parameter int IDW     = 3
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               valid_o,
    output logic [IDW-1:0]     idx_o
);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/isq_seq_fsm.sv
module isq_seq_fsm
    import isq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PC_W    = 10,
    parameter int IDW     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic [IDW-1:0]     req_idx_i,
    input  logic               instr_retire_i,
    input  logic               reti_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [PC_W-1:0]    pop_data_i,
    input  logic               gie_wr_i,
    input  logic               gie_wdata_i,
    output logic               gie_o,
    output logic               hold_o,
    output logic               ack_o,
    output logic [IDW-1:0]     ack_id_o,
    output logic [NUM_SRC-1:0] hw_clr_o,
    output logic               push_o,
    output logic [PC_W-1:0]    push_data_o,
    output logic               pop_o,
    output logic               pc_load_o,
    output logic [PC_W-1:0]    pc_load_addr_o
);

    localparam logic [SEQ_CNT_W-1:0] ENTRY_LAST  = SEQ_CNT_W'(ENTRY_CYCLES - 1);
    localparam logic [SEQ_CNT_W-1:0] JUMP_LAST   = SEQ_CNT_W'(JUMP_CYCLES - 1);
    localparam logic [SEQ_CNT_W-1:0] RETURN_LAST = SEQ_CNT_W'(RETURN_CYCLES - 1);
    localparam logic [SEQ_CNT_W-1:0] ACK_SLOT    = SEQ_CNT_W'(0);
    localparam logic [SEQ_CNT_W-1:0] PUSH_SLOT   = SEQ_CNT_W'(1);
    localparam logic [SEQ_CNT_W-1:0] POP_SLOT    = SEQ_CNT_W'(0);
    localparam logic [SEQ_CNT_W-1:0] CAPT_SLOT   = SEQ_CNT_W'(1);

    isq_state_e             state_q, state_n;
    logic [SEQ_CNT_W-1:0]   cnt_q, cnt_n;
    logic [IDW-1:0]         sel_q, sel_n;
    logic [PC_W-1:0]        ret_pc_q, ret_pc_n;
    logic                   gie_q, gie_n;

    // Next-state and datapath decisions
    always_comb begin
        state_n  = state_q;
        cnt_n    = cnt_q;
        sel_n    = sel_q;
        ret_pc_n = ret_pc_q;
        gie_n    = gie_q;
        unique case (state_q)
            ST_RUN: begin
                if (instr_retire_i && reti_i) begin
                    state_n = ST_RETURN;
                    cnt_n   = '0;
                end else if (instr_retire_i && gie_q && req_valid_i) begin
                    state_n  = ST_ENTRY;
                    cnt_n    = '0;
                    sel_n    = req_idx_i;
                    ret_pc_n = pc_i;
                    gie_n    = 1'b0;
                end else if (gie_wr_i) begin
                    gie_n = gie_wdata_i;
                end
            end
            ST_ENTRY: begin
                if (cnt_q == ENTRY_LAST) begin
                    state_n = ST_JUMP;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_JUMP: begin
                if (cnt_q == JUMP_LAST) begin
                    state_n = ST_RUN;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_RETURN: begin
                if (cnt_q == CAPT_SLOT) begin
                    ret_pc_n = pop_data_i;
                end
                if (cnt_q == RETURN_LAST) begin
                    state_n = ST_ONE_INSN;
                    cnt_n   = '0;
                    gie_n   = 1'b1;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_ONE_INSN: begin
                if (instr_retire_i && reti_i) begin
                    state_n = ST_RETURN;
                    cnt_n   = '0;
                end else begin
                    if (instr_retire_i) begin
                        state_n = ST_RUN;
                    end
                    if (gie_wr_i) begin
                        gie_n = gie_wdata_i;
                    end
                end
            end
            default: begin
                state_n = ST_RUN;
                cnt_n   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            cnt_q    <= '0;
            sel_q    <= '0;
            ret_pc_q <= '0;
            gie_q    <= 1'b0;
        end else begin
            state_q  <= state_n;
            cnt_q    <= cnt_n;
            sel_q    <= sel_n;
            ret_pc_q <= ret_pc_n;
            gie_q    <= gie_n;
        end
    end

    // Moore outputs
    always_comb begin
        ack_o          = 1'b0;
        push_o         = 1'b0;
        pop_o          = 1'b0;
        pc_load_o      = 1'b0;
        pc_load_addr_o = ret_pc_q;
        hold_o         = 1'b0;
        hw_clr_o       = '0;
        unique case (state_q)
            ST_ENTRY: begin
                hold_o = 1'b1;
                ack_o  = (cnt_q == ACK_SLOT);
                push_o = (cnt_q == PUSH_SLOT);
                if (cnt_q == ACK_SLOT) begin
                    hw_clr_o[sel_q] = 1'b1;
                end
            end
            ST_JUMP: begin
                hold_o         = 1'b1;
                pc_load_o      = (cnt_q == JUMP_LAST);
                pc_load_addr_o = PC_W'(sel_q) + PC_W'(1);
            end
            ST_RETURN: begin
                hold_o    = 1'b1;
                pop_o     = (cnt_q == POP_SLOT);
                pc_load_o = (cnt_q == RETURN_LAST);
            end
            ST_RUN, ST_ONE_INSN: begin
                hold_o = 1'b0;
            end
            default: begin
                hold_o = 1'b0;
            end
        endcase
    end

    assign gie_o       = gie_q;
    assign ack_id_o    = sel_q;
    assign push_data_o = ret_pc_q;

endmodule

// File: rtl/isq_top.sv
module isq_top #(
    parameter int NUM_SRC = 8,
    parameter int PC_W    = 10,
    localparam int IDW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_set_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               flag_clr_we_i,
    input  logic [NUM_SRC-1:0] flag_clr_data_i,
    input  logic               gie_wr_i,
    input  logic               gie_wdata_i,
    input  logic               instr_retire_i,
    input  logic               reti_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [PC_W-1:0]    pop_data_i,
    output logic [NUM_SRC-1:0] flags_o,
    output logic               gie_o,
    output logic               hold_o,
    output logic               ack_o,
    output logic [IDW-1:0]     ack_id_o,
    output logic               push_o,
    output logic [PC_W-1:0]    push_data_o,
    output logic               pop_o,
    output logic               pc_load_o,
    output logic [PC_W-1:0]    pc_load_addr_o
);

    logic [NUM_SRC-1:0] hw_clr;
    logic [NUM_SRC-1:0] cand;
    logic               cand_valid;
    logic [IDW-1:0]     cand_idx;

    isq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (irq_set_i),
        .clr_we_i   (flag_clr_we_i),
        .clr_data_i (flag_clr_data_i),
        .hw_clr_i   (hw_clr),
        .flags_o    (flags_o)
    );

    assign cand = flags_o & src_en_i;

    isq_prio_enc #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_prio (
        .req_i   (cand),
        .valid_o (cand_valid),
        .idx_o   (cand_idx)
    );

    isq_seq_fsm #(.NUM_SRC(NUM_SRC), .PC_W(PC_W), .IDW(IDW)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid_i    (cand_valid),
        .req_idx_i      (cand_idx),
        .instr_retire_i (instr_retire_i),
        .reti_i         (reti_i),
        .pc_i           (pc_i),
        .pop_data_i     (pop_data_i),
        .gie_wr_i       (gie_wr_i),
        .gie_wdata_i    (gie_wdata_i),
        .gie_o          (gie_o),
        .hold_o         (hold_o),
        .ack_o          (ack_o),
        .ack_id_o       (ack_id_o),
        .hw_clr_o       (hw_clr),
        .push_o         (push_o),
        .push_data_o    (push_data_o),
        .pop_o          (pop_o),
        .pc_load_o      (pc_load_o),
        .pc_load_addr_o (pc_load_addr_o)
    );

endmodule

// File: rtl/isq_checker.sv
module isq_checker #(
    parameter int NUM_SRC = 8,
    parameter int PC_W    = 10,
    parameter int IDW     = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_set_i,
    input logic               flag_clr_we_i,
    input logic               instr_retire_i,
    input logic               reti_i,
    input logic [PC_W-1:0]    pc_i,
    input logic [NUM_SRC-1:0] flags_o,
    input logic               gie_o,
    input logic               hold_o,
    input logic               ack_o,
    input logic [IDW-1:0]     ack_id_o,
    input logic               push_o,
    input logic [PC_W-1:0]    push_data_o,
    input logic               pop_o
);

    assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set_i == '0 && !flag_clr_we_i && !ack_o) |=> flags_o == $past(flags_o));

    assert_ack_on_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(instr_retire_i));

    assert_ack_was_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (($past(flags_o) >> ack_id_o) & NUM_SRC'(1)) != '0);

    assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    assert_ack_gie_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !gie_o);

    assert_push_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> push_o);

    assert_push_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> push_data_o == $past(pc_i, 2));

    assert_push_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> hold_o);

    assert_pop_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |=> !pop_o);

    assert_pop_after_reti_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |-> $past(reti_i && instr_retire_i));

endmodule

bind isq_top isq_checker #(.NUM_SRC(NUM_SRC), .PC_W(PC_W), .IDW(IDW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .irq_set_i      (irq_set_i),
    .flag_clr_we_i  (flag_clr_we_i),
    .instr_retire_i (instr_retire_i),
    .reti_i         (reti_i),
    .pc_i           (pc_i),
    .flags_o        (flags_o),
    .gie_o          (gie_o),
    .hold_o         (hold_o),
    .ack_o          (ack_o),
    .ack_id_o       (ack_id_o),
    .push_o         (push_o),
    .push_data_o    (push_data_o),
    .pop_o          (pop_o)
);

// File: tb/isq_top_tb_top.sv
module isq_top_tb_top;

    localparam int N  = 8;
    localparam int PW = 10;
    localparam int EV_ACK = 0, EV_PUSH = 1, EV_POP = 2, EV_LOAD = 3;

    typedef struct { int kind; int val; int at; } ev_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_set_i = '0;
    logic [N-1:0]  src_en_i = '0;
    logic          flag_clr_we_i = 1'b0;
    logic [N-1:0]  flag_clr_data_i = '0;
    logic          gie_wr_i = 1'b0;
    logic          gie_wdata_i = 1'b0;
    logic          instr_retire_i = 1'b0;
    logic          reti_i = 1'b0;
    logic [PW-1:0] pc_i = '0;
    logic [PW-1:0] pop_data_i = '0;
    logic [N-1:0]  flags_o;
    logic          gie_o, hold_o, ack_o, push_o, pop_o, pc_load_o;
    logic [2:0]    ack_id_o;
    logic [PW-1:0] push_data_o, pc_load_addr_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    ev_t sb_q[$];
    logic [PW-1:0] stk[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    isq_top #(.NUM_SRC(N), .PC_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_set_i(irq_set_i), .src_en_i(src_en_i),
        .flag_clr_we_i(flag_clr_we_i), .flag_clr_data_i(flag_clr_data_i),
        .gie_wr_i(gie_wr_i), .gie_wdata_i(gie_wdata_i),
        .instr_retire_i(instr_retire_i), .reti_i(reti_i), .pc_i(pc_i),
        .pop_data_i(pop_data_i), .flags_o(flags_o), .gie_o(gie_o),
        .hold_o(hold_o), .ack_o(ack_o), .ack_id_o(ack_id_o), .push_o(push_o),
        .push_data_o(push_data_o), .pop_o(pop_o), .pc_load_o(pc_load_o),
        .pc_load_addr_o(pc_load_addr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(input int kind, input int val, input int at);
        ev_t e;
        e.kind = kind; e.val = val; e.at = at;
        sb_q.push_back(e);
    endtask

    task automatic observe(input int kind, input int val);
        ev_t e;
        if (sb_q.size() == 0) begin
            chk(1'b0, "R4/R8 unexpected strobe", kind, -1);
        end else begin
            e = sb_q.pop_front();
            chk(e.kind == kind, "R5-R8 strobe kind", kind, e.kind);
            chk(e.val == val, "R5-R8 strobe value", val, e.val);
            chk(e.at == cyc, "R5-R8 strobe cycle", cyc, e.at);
        end
    endtask

    // Monitor: compares produced strobes against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_o)     observe(EV_ACK, int'(ack_id_o));
            if (push_o)    observe(EV_PUSH, int'(push_data_o));
            if (pop_o)     observe(EV_POP, 0);
            if (pc_load_o) observe(EV_LOAD, int'(pc_load_addr_o));
        end
    end

    // Stack memory model
    always @(negedge clk) begin
        if (rst_n) begin
            if (push_o) stk.push_back(push_data_o);
            if (pop_o && stk.size() > 0) pop_data_i = stk.pop_back();
        end
    end

    // Driver: one retire; queues the expected strobes first
    task automatic step(input bit is_reti, input logic [PW-1:0] pc,
                        input int ack_id, input int ret_addr);
        int e;
        @(negedge clk);
        e = cyc + 1;
        if (ack_id >= 0) begin
            expect_ev(EV_ACK, ack_id, e);
            expect_ev(EV_PUSH, int'(pc), e + 1);
            expect_ev(EV_LOAD, ack_id + 1, e + 5);
        end
        if (ret_addr >= 0) begin
            expect_ev(EV_POP, 0, e);
            expect_ev(EV_LOAD, ret_addr, e + 3);
        end
        instr_retire_i = 1'b1; reti_i = is_reti; pc_i = pc;
        @(negedge clk);
        instr_retire_i = 1'b0; reti_i = 1'b0;
    endtask

    task automatic pulse_set(input logic [N-1:0] v);
        @(negedge clk); irq_set_i = v;
        @(negedge clk); irq_set_i = '0;
    endtask

    task automatic w1c(input logic [N-1:0] v);
        @(negedge clk); flag_clr_we_i = 1'b1; flag_clr_data_i = v;
        @(negedge clk); flag_clr_we_i = 1'b0; flag_clr_data_i = '0;
    endtask

    task automatic gie_write(input bit v);
        @(negedge clk); gie_wr_i = 1'b1; gie_wdata_i = v;
        @(negedge clk); gie_wr_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        chk(flags_o == '0, "R1 flags in reset", flags_o, 0);
        chk(!gie_o && !hold_o, "R1 gie/hold in reset", {gie_o, hold_o}, 0);
        chk(!ack_o && !push_o && !pop_o && !pc_load_o, "R1 strobes in reset",
            {ack_o, push_o, pop_o, pc_load_o}, 0);
        rst_n = 1'b1;
        src_en_i = '1;

        // R2: flags latch while the global enable is off
        pulse_set(8'h28);
        chk(flags_o == 8'h28, "R2 flags latched", flags_o, 8'h28);
        step(1'b0, 10'h050, -1, -1);
        idle(8);
        chk(flags_o == 8'h28, "R2 held under global disable", flags_o, 8'h28);

        // R3: write-one-to-clear
        w1c(8'h00);
        chk(flags_o == 8'h28, "R3 zero write no effect", flags_o, 8'h28);
        w1c(8'h20);
        chk(flags_o == 8'h08, "R3 clear bit 5", flags_o, 8'h08);
        @(negedge clk); irq_set_i = 8'h02; flag_clr_we_i = 1'b1; flag_clr_data_i = 8'h02;
        @(negedge clk); irq_set_i = '0; flag_clr_we_i = 1'b0; flag_clr_data_i = '0;
        chk(flags_o == 8'h0A, "R3 set beats clear", flags_o, 8'h0A);
        w1c(8'h02);
        chk(flags_o == 8'h08, "R3 clear bit 1", flags_o, 8'h08);

        // R10 and R2: global on, source masked
        gie_write(1'b1);
        chk(gie_o, "R10 gie written 1", gie_o, 1);
        src_en_i = ~8'h08;
        step(1'b0, 10'h051, -1, -1);
        idle(8);
        chk(flags_o == 8'h08, "R2 held under source mask", flags_o, 8'h08);
        src_en_i = '1;
        pulse_set(8'h40);

        // R4-R7: accept source 3 (beats 6)
        step(1'b0, 10'h123, 3, -1);
        chk(!gie_o, "R5 gie cleared on entry", gie_o, 0);
        idle(5);
        chk(hold_o, "R7 hold in sixth cycle", hold_o, 1);
        idle(1);
        chk(!hold_o, "R7 hold released", hold_o, 0);
        chk(flags_o == 8'h40, "R5 flag 3 cleared at vectoring", flags_o, 8'h40);
        step(1'b0, 10'h130, -1, -1);
        idle(4);

        // R8: return
        step(1'b1, 10'h131, -1, 10'h123);
        idle(4);
        chk(gie_o, "R8 gie restored", gie_o, 1);
        chk(!hold_o, "R8 hold released", hold_o, 0);

        // R9: first retire after the return is never accepted
        step(1'b0, 10'h124, -1, -1);
        idle(4);
        chk(flags_o == 8'h40, "R9 source 6 still pending", flags_o, 8'h40);
        step(1'b0, 10'h125, 6, -1);
        irq_set_i = 8'h40;           // set pulse in the acknowledge cycle
        @(negedge clk); irq_set_i = '0;
        idle(6);
        chk(flags_o == 8'h40, "R5 set in ack cycle keeps flag", flags_o, 8'h40);

        // R11: return wins over a pending candidate
        gie_write(1'b1);
        step(1'b1, 10'h140, -1, 10'h125);
        idle(4);
        chk(gie_o, "R11 gie after return", gie_o, 1);
        step(1'b0, 10'h126, -1, -1);
        idle(2);
        step(1'b0, 10'h127, 6, -1);
        idle(7);
        chk(flags_o == 8'h00, "R4 flag 6 serviced", flags_o, 0);
        step(1'b1, 10'h141, -1, 10'h127);
        idle(5);
        step(1'b0, 10'h128, -1, -1);
        idle(2);
        gie_write(1'b0);
        chk(!gie_o, "R10 gie written 0", gie_o, 0);
        chk(sb_q.size() == 0, "R4-R8 all expected strobes seen", sb_q.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule